// File: doc/BRIEF.md
# Receive Flow-Control Credit Tracker

This block keeps the count of free receive buffers for one flow-control group of a multi-channel DMA engine. Two channels share a group, and the group number is the channel number shifted right by one. Software adds buffers by writing an allocation register. It can also load the count outright by setting the top bit of that write. The receive engine sends a one-cycle pulse each time it fills a descriptor, and that pulse removes one credit.

The tracker compares the count with two programmable water marks and drives a pause output toward the peripheral, with hysteresis between the marks. Pause starts when the free count drops to the low mark or below. Pause ends only when the count climbs back to the high mark or above. Software usually sets the marks to about one third and two thirds of the receive ring size.

The block is reached through a plain write port and a combinational read port. The configuration register sits at byte 0x00. Each group owns three registers, spaced 12 bytes apart per group. The instance decodes only its own group's registers, chosen by a parameter.

Top module: `fc_credit_tracker`

## Requirements
- R1: After reset the count is 0, pause and underflow are low, and the configuration, low-mark, high-mark and allocation registers all read 0.
- R2: A write to the allocation register with bit 31 clear adds bits [CNT_W-1:0] of the data to the count. The sum saturates at 2^CNT_W-1.
- R3: A write to the allocation register with bit 31 set loads the count with bits [CNT_W-1:0] of the data. A consume pulse in the same cycle is ignored.
- R4: Each consume pulse removes one credit. An addition in the same cycle is netted against it, so the count changes by N-1.
- R5: A consume pulse when the count is 0 and no credit arrives in that cycle leaves the count at 0. It raises underflow for exactly the following cycle.
- R6: While flow control is active, pause is high whenever the count is at or below the low mark. The low-mark test wins if the marks overlap.
- R7: While flow control is active, pause keeps its previous value for counts strictly between the marks. Pause drops once the count is at or above the high mark.
- R8: Flow control is active only when configuration bit 0 (global enable) and bit GROUP_IDX+1 (group enable) are both set. Otherwise pause is held low, and credits are still counted.
- R9: For group g, the low mark is at 0x04+12g, the high mark at 0x08+12g and the allocation register at 0x0C+12g. Marks read back their value. An allocation read returns the count in bits [CNT_W-1:0]. Writes to any other address change nothing.
- R10: The count, pause and underflow all reflect a write or a consume pulse at the first rising edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data; bit DATA_W-1 is the force flag on allocation writes |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | DATA_W | Combinational read data |
| buf_taken | input | 1 | One-cycle pulse: the engine filled a descriptor |
| pause_o | output | 1 | Back-pressure toward the peripheral |
| underflow_o | output | 1 | One-cycle pulse: a credit was consumed with none left |

## Verification
Every result is due one rising edge after its stimulus. The count, the underflow pulse and pause are all registered from next-state values, including the register values that the same edge writes. The bench drives inputs on the falling edge and withdraws them shortly after the rising edge. It then samples count, pause and underflow at the next falling edge, so each vector sees exactly one edge of effect. Register read-back is combinational, so those checks change the read address and sample a nanosecond later, without any clock edge.

// File: rtl/fc_credit_pkg.sv
package fc_credit_pkg;
  localparam int unsigned CFG_ADDR   = 0;
  localparam int unsigned GRP_STRIDE = 12;
  localparam int unsigned OFF_LO     = 4;
  localparam int unsigned OFF_HI     = 8;
  localparam int unsigned OFF_ALLOC  = 12;

  typedef enum logic [1:0] {SEL_NONE, SEL_LO, SEL_HI, SEL_ALLOC} grp_sel_e;

  function automatic int unsigned grp_addr(int unsigned grp, int unsigned off);
    return grp * GRP_STRIDE + off;
  endfunction
endpackage

// File: rtl/fc_regs.sv
module fc_regs
  import fc_credit_pkg::*;
#(
  parameter int unsigned GROUP_IDX = 1,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              glb_en,
  output logic              grp_en,
  output logic [CNT_W-1:0]  lo_mark,
  output logic [CNT_W-1:0]  hi_mark,
  output logic              act_nx,
  output logic [CNT_W-1:0]  lo_nx,
  output logic [CNT_W-1:0]  hi_nx,
  output logic              add_ev,
  output logic              force_ev,
  output logic [CNT_W-1:0]  wr_val
);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] A_LO    = ADDR_W'(grp_addr(GROUP_IDX, OFF_LO));
  localparam logic [ADDR_W-1:0] A_HI    = ADDR_W'(grp_addr(GROUP_IDX, OFF_HI));
  localparam logic [ADDR_W-1:0] A_ALLOC = ADDR_W'(grp_addr(GROUP_IDX, OFF_ALLOC));
  localparam int unsigned       GBIT    = GROUP_IDX + 1;

  logic cfg_hit, lo_hit, hi_hit, alloc_hit;
  logic glb_nx, grp_nx;
  logic unused_mid;

  assign cfg_hit   = wr_en && (wr_addr == A_CFG);
  assign lo_hit    = wr_en && (wr_addr == A_LO);
  assign hi_hit    = wr_en && (wr_addr == A_HI);
  assign alloc_hit = wr_en && (wr_addr == A_ALLOC);

  assign wr_val   = wr_data[CNT_W-1:0];
  assign force_ev = alloc_hit && wr_data[DATA_W-1];
  assign add_ev   = alloc_hit && !wr_data[DATA_W-1];
  assign unused_mid = ^wr_data[DATA_W-2:CNT_W];

  assign glb_nx = cfg_hit ? wr_data[0]    : glb_en;
  assign grp_nx = cfg_hit ? wr_data[GBIT] : grp_en;
  assign lo_nx  = lo_hit  ? wr_val        : lo_mark;
  assign hi_nx  = hi_hit  ? wr_val        : hi_mark;
  assign act_nx = glb_nx && grp_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en  <= 1'b0;
      grp_en  <= 1'b0;
      lo_mark <= '0;
      hi_mark <= '0;
    end else begin
      glb_en  <= glb_nx;
      grp_en  <= grp_nx;
      lo_mark <= lo_nx;
      hi_mark <= hi_nx;
    end
  end
endmodule

// File: rtl/fc_credit_counter.sv
module fc_credit_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_ev,
  input  logic             force_ev,
  input  logic             take,
  input  logic [CNT_W-1:0] val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nx,
  output logic             uf_ev,
  output logic             underflow
);
  localparam int unsigned          WW   = CNT_W + 2;
  localparam logic [WW-1:0]        CMAX = WW'({CNT_W{1'b1}});

  // returns {underflow, next count}
  function automatic logic [CNT_W:0] step(logic [CNT_W-1:0] c, logic a, logic f,
                                          logic t, logic [CNT_W-1:0] v);
    logic [WW-1:0] s;
    logic          u;
    if (f) return {1'b0, v};
    s = WW'(c) + (a ? WW'(v) : '0);
    u = 1'b0;
    if (t) begin
      if (s == '0) u = 1'b1;
      else         s = s - 1'b1;
    end
    if (s > CMAX) s = CMAX;
    return {u, s[CNT_W-1:0]};
  endfunction

  assign {uf_ev, cnt_nx} = step(cnt, add_ev, force_ev, take, val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      underflow <= 1'b0;
    end else begin
      cnt       <= cnt_nx;
      underflow <= uf_ev;
    end
  end
endmodule

// File: rtl/fc_hysteresis.sv
module fc_hysteresis #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_nx,
  input  logic [CNT_W-1:0] cnt_nx,
  input  logic [CNT_W-1:0] lo_nx,
  input  logic [CNT_W-1:0] hi_nx,
  output logic             pause
);
  function automatic logic decide(logic en, logic [CNT_W-1:0] c,
                                  logic [CNT_W-1:0] lo, logic [CNT_W-1:0] hi,
                                  logic held);
    if (!en)     return 1'b0;
    if (c <= lo) return 1'b1;
    if (c >= hi) return 1'b0;
    return held;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pause <= 1'b0;
    else        pause <= decide(act_nx, cnt_nx, lo_nx, hi_nx, pause);
  end
endmodule

// File: rtl/fc_credit_tracker.sv
module fc_credit_tracker
  import fc_credit_pkg::*;
#(
  parameter int unsigned GROUP_IDX = 1,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              buf_taken,
  output logic              pause_o,
  output logic              underflow_o
);
  localparam int unsigned GBIT = GROUP_IDX + 1;

  logic             glb_en, grp_en, act_nx;
  logic [CNT_W-1:0] lo_mark, hi_mark, lo_nx, hi_nx;
  logic             add_ev, force_ev, take_ev, uf_ev;
  logic [CNT_W-1:0] wr_val, cnt, cnt_nx;
  logic             flow_act;
  grp_sel_e         rd_sel;

  assign take_ev  = buf_taken;
  assign flow_act = glb_en && grp_en;

  fc_regs #(.GROUP_IDX(GROUP_IDX), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .glb_en(glb_en), .grp_en(grp_en), .lo_mark(lo_mark), .hi_mark(hi_mark),
    .act_nx(act_nx), .lo_nx(lo_nx), .hi_nx(hi_nx),
    .add_ev(add_ev), .force_ev(force_ev), .wr_val(wr_val)
  );

  fc_credit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .add_ev(add_ev), .force_ev(force_ev), .take(take_ev),
    .val(wr_val), .cnt(cnt), .cnt_nx(cnt_nx), .uf_ev(uf_ev), .underflow(underflow_o)
  );

  fc_hysteresis #(.CNT_W(CNT_W)) u_hys (
    .clk(clk), .rst_n(rst_n), .act_nx(act_nx), .cnt_nx(cnt_nx),
    .lo_nx(lo_nx), .hi_nx(hi_nx), .pause(pause_o)
  );

  always_comb begin
    if (rd_addr == ADDR_W'(grp_addr(GROUP_IDX, OFF_LO)))         rd_sel = SEL_LO;
    else if (rd_addr == ADDR_W'(grp_addr(GROUP_IDX, OFF_HI)))    rd_sel = SEL_HI;
    else if (rd_addr == ADDR_W'(grp_addr(GROUP_IDX, OFF_ALLOC))) rd_sel = SEL_ALLOC;
    else                                                         rd_sel = SEL_NONE;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(CFG_ADDR)) begin
      rd_data[0]    = glb_en;
      rd_data[GBIT] = grp_en;
    end else begin
      case (rd_sel)
        SEL_LO:    rd_data[CNT_W-1:0] = lo_mark;
        SEL_HI:    rd_data[CNT_W-1:0] = hi_mark;
        SEL_ALLOC: rd_data[CNT_W-1:0] = cnt;
        default:   rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/fc_credit_tracker_chk.sv
module fc_credit_tracker_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             add_ev,
  input logic             force_ev,
  input logic             take_ev,
  input logic [CNT_W-1:0] wr_val,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] lo_mark,
  input logic [CNT_W-1:0] hi_mark,
  input logic             flow_act,
  input logic             pause_o,
  input logic             underflow_o
);
  // R2
  add_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_ev && !take_ev |=> cnt >= $past(cnt));
  // R3
  force_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_ev |=> cnt == $past(wr_val) && !underflow_o);
  // R4
  take_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev && !add_ev && !force_ev && cnt != '0 |=> cnt == $past(cnt) - 1'b1);
  // R5
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev && !add_ev && !force_ev && cnt == '0 |=> underflow_o && cnt == '0);
  // R5
  no_spurious_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_ev |=> !underflow_o);
  // R6
  pause_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flow_act && cnt <= lo_mark |-> pause_o);
  // R7
  pause_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flow_act && cnt >= hi_mark && cnt > lo_mark |-> !pause_o);
  // R8
  pause_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_act |-> !pause_o);
endmodule

bind fc_credit_tracker fc_credit_tracker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .add_ev(add_ev), .force_ev(force_ev), .take_ev(take_ev),
  .wr_val(wr_val), .cnt(cnt), .lo_mark(lo_mark), .hi_mark(hi_mark),
  .flow_act(flow_act), .pause_o(pause_o), .underflow_o(underflow_o)
);

// File: tb/fc_credit_tracker_bench.sv
module fc_credit_tracker_bench;
  localparam int unsigned G = 1;
  localparam logic [7:0] A_CFG = 8'h00;
  localparam logic [7:0] A_LO  = 8'h04 + 8'(12 * G);
  localparam logic [7:0] A_HI  = 8'h08 + 8'(12 * G);
  localparam logic [7:0] A_AL  = 8'h0C + 8'(12 * G);
  localparam logic [31:0] FORCE = 32'h8000_0000;
  localparam int NV = 16;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic        take;
    logic [7:0]  e_cnt;
    logic        e_pause;
    logic        e_uf;
  } vec_t;

  // group enable is cfg bit G+1 = bit 2, global bit 0 -> 0x5
  localparam vec_t VEC [NV] = '{
    '{1'b1, A_LO,  32'd2,         1'b0, 8'd0, 1'b0, 1'b0},
    '{1'b1, A_HI,  32'd5,         1'b0, 8'd0, 1'b0, 1'b0},
    '{1'b1, A_CFG, 32'h5,         1'b0, 8'd0, 1'b1, 1'b0},
    '{1'b1, A_AL,  32'd3,         1'b0, 8'd3, 1'b1, 1'b0},
    '{1'b1, A_AL,  32'd2,         1'b1, 8'd4, 1'b1, 1'b0},
    '{1'b1, A_AL,  32'd1,         1'b0, 8'd5, 1'b0, 1'b0},
    '{1'b0, A_CFG, 32'd0,         1'b1, 8'd4, 1'b0, 1'b0},
    '{1'b0, A_CFG, 32'd0,         1'b1, 8'd3, 1'b0, 1'b0},
    '{1'b0, A_CFG, 32'd0,         1'b1, 8'd2, 1'b1, 1'b0},
    '{1'b1, A_AL,  FORCE | 32'd9, 1'b0, 8'd9, 1'b0, 1'b0},
    '{1'b1, A_AL,  FORCE,         1'b1, 8'd0, 1'b1, 1'b0},
    '{1'b0, A_CFG, 32'd0,         1'b1, 8'd0, 1'b1, 1'b1},
    '{1'b0, A_CFG, 32'd0,         1'b0, 8'd0, 1'b1, 1'b0},
    '{1'b1, A_CFG, 32'h1,         1'b0, 8'd0, 1'b0, 1'b0},
    '{1'b1, A_AL,  32'd7,         1'b0, 8'd7, 1'b0, 1'b0},
    '{1'b0, A_CFG, 32'd0,         1'b1, 8'd6, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, buf_taken = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = A_AL;
  logic [31:0] wr_data = '0, rd_data;
  logic pause_o, underflow_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fc_credit_tracker u_fc_credit_tracker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .buf_taken(buf_taken),
    .pause_o(pause_o), .underflow_o(underflow_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(logic w, logic [7:0] a, logic [31:0] d, logic t);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; buf_taken = t;
    @(posedge clk);
    #2;
    wr_en = 1'b0; buf_taken = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_chk(string req, logic [7:0] a, logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
    rd_addr = A_AL;
    #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", rd_data, 32'd0);
    chk("R1 pause", {31'd0, pause_o}, 32'd0);
    read_chk("R1 cfg", A_CFG, 32'd0);
    read_chk("R1 lo", A_LO, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].wr, VEC[i].addr, VEC[i].data, VEC[i].take);
      chk($sformatf("R10 vec%0d count", i), rd_data, {24'd0, VEC[i].e_cnt});
      chk($sformatf("R6/R7/R8 vec%0d pause", i), {31'd0, pause_o}, {31'd0, VEC[i].e_pause});
      chk($sformatf("R5 vec%0d underflow", i), {31'd0, underflow_o}, {31'd0, VEC[i].e_uf});
    end

    // R9 read-back of marks and config
    read_chk("R9 lo", A_LO, 32'd2);
    read_chk("R9 hi", A_HI, 32'd5);
    read_chk("R9 cfg", A_CFG, 32'h1);

    // R9 writes to another group's registers and unmapped addresses do nothing
    drive(1'b1, 8'h04, 32'd9, 1'b0);
    read_chk("R9 foreign lo ignored", A_LO, 32'd2);
    read_chk("R9 foreign lo reads zero", 8'h04, 32'd0);
    drive(1'b1, 8'h1C, FORCE | 32'd1, 1'b0);
    chk("R9 unmapped write count", rd_data, 32'd6);

    // R2 saturation
    drive(1'b1, A_AL, FORCE | 32'd250, 1'b0);
    chk("R3 force 250", rd_data, 32'd250);
    drive(1'b1, A_AL, 32'd10, 1'b0);
    chk("R2 saturate", rd_data, 32'd255);
    drive(1'b1, A_AL, 32'd10, 1'b1);
    chk("R2 saturate with take", rd_data, 32'd255);

    // R6 overlapping marks: low test wins
    drive(1'b1, A_CFG, 32'h5, 1'b0);
    drive(1'b1, A_LO, 32'd255, 1'b0);
    chk("R6 overlap pause", {31'd0, pause_o}, 32'd1);

    // R1 mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset count", rd_data, 32'd0);
    chk("R1 reset pause", {31'd0, pause_o}, 32'd0);
    read_chk("R1 reset hi", A_HI, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule